// File: doc/BRIEF.md
# Byte Data Request and Lost-Data Tracker

This block sits between a host bus and a disk serializer during sector and track transfers. A data byte moves at a fixed rate, and neither side can stall the stream. On a read, every byte assembled from the disk is loaded into a holding register, and a request flag tells the host to collect it. On a write, the request flag tells the host that the holding register is empty and the serializer needs the next byte.

A one-cycle byte strobe from the serializer marks each byte slot. If the host has not serviced the request by the next strobe, the block does not apply back-pressure. It latches a sticky lost-data flag and the transfer carries on. A read overrun overwrites the register with the new byte. A write underrun sends a zero byte to the disk.

The request and lost flags are meant to be shown as status bits 1 and 2 while a sector or track command runs. Both flags are cleared when a new command starts.

Top module: `drq_lost_tracker`

## Requirements
- R1: After reset, `drq` is 0, `lost` is 0 and `dreg` is zero.
- R2: A `start` pulse clears `lost` and `dreg` on the next clock. It raises `drq` if `wr_mode` is 1 (write), so the host can preload the first byte, and clears `drq` if `wr_mode` is 0 (read).
- R3: In read mode, a `byte_tick` loads `disk_byte` into `dreg` and sets `drq` on the next clock.
- R4: In read mode, a `host_rd` pulse without a tick clears `drq` on the next clock. In write mode, a `host_wr` pulse without a tick loads `host_din` into `dreg` and clears `drq` on the next clock.
- R5: In read mode, a tick that arrives while `drq` is still 1 and `host_rd` is 0 sets `lost`. The new byte still overwrites `dreg`, and `drq` stays 1.
- R6: In write mode, during a tick with `drq` at 0, `disk_out` equals `dreg`, and `drq` is 1 on the next clock. A `host_wr` in the same cycle as a tick with `drq` at 1 counts as on time, and its `host_din` appears on `disk_out`.
- R7: In write mode, a tick with `drq` at 1 and no `host_wr` drives `disk_out` to zero and sets `lost` on the next clock.
- R8: Once set, `lost` stays 1 through later ticks and host accesses until the next `start`. The transfer keeps running after a miss.
- R9: A `stop` pulse clears `drq` and leaves `lost` unchanged. While no transfer is active, ticks change neither `drq` nor `dreg`.
- R10: A host access in the wrong direction is ignored. A `host_wr` during a read transfer leaves `dreg` and `drq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start pulse; clears flags and begins a transfer |
| wr_mode | input | 1 | Transfer direction sampled at start: 1 write, 0 read |
| stop | input | 1 | End of transfer pulse |
| byte_tick | input | 1 | Byte-slot strobe from the serializer |
| disk_byte | input | DW | Byte assembled from the disk |
| host_rd | input | 1 | Host read pulse on the data register |
| host_wr | input | 1 | Host write pulse on the data register |
| host_din | input | DW | Host write data |
| drq | output | 1 | Data request (status bit 1) |
| lost | output | 1 | Sticky lost-data flag (status bit 2) |
| dreg | output | DW | Data register value |
| disk_out | output | DW | Byte handed to the serializer on a write tick |

## Verification
On every cycle, the assertions check these rules: `lost` stays sticky until a start, every active tick leaves a request pending, a read service drops the request, an underrun sends a zero byte, an idle block holds no request, and `lost` rises only after a tick that found the request unserviced. Some behaviours only the bench scenarios can show. These are the actual byte values that pass through the register in a mixed stream, the same-cycle service race at a tick, a wrong-direction access that leaves the register untouched, and the clearing of `lost` by a fresh command after a stop.

// File: rtl/drq_lost_tracker.sv
module drq_lost_tracker #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_mode,
  input  logic          stop,
  input  logic          byte_tick,
  input  logic [DW-1:0] disk_byte,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_din,
  output logic          drq,
  output logic          lost,
  output logic [DW-1:0] dreg,
  output logic [DW-1:0] disk_out
);

  logic active, wmode;

  wire rd_go = active & ~wmode;
  wire wr_go = active &  wmode;

  assign disk_out = (byte_tick && drq) ? (host_wr ? host_din : '0) : dreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      wmode  <= 1'b0;
      drq    <= 1'b0;
      lost   <= 1'b0;
      dreg   <= '0;
    end else if (start) begin
      active <= 1'b1;
      wmode  <= wr_mode;
      drq    <= wr_mode;
      lost   <= 1'b0;
      dreg   <= '0;
    end else if (stop) begin
      active <= 1'b0;
      drq    <= 1'b0;
    end else if (rd_go) begin
      if (byte_tick) begin
        dreg <= disk_byte;
        drq  <= 1'b1;
        if (drq && !host_rd) lost <= 1'b1;
      end else if (host_rd) begin
        drq <= 1'b0;
      end
    end else if (wr_go) begin
      if (host_wr) dreg <= host_din;
      if (byte_tick) begin
        drq <= 1'b1;
        if (drq && !host_wr) lost <= 1'b1;
      end else if (host_wr) begin
        drq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/drq_lost_tracker_chk.sv
module drq_lost_tracker_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic          wr_mode,
  input logic          byte_tick,
  input logic          host_rd,
  input logic          host_wr,
  input logic          active,
  input logic          wmode,
  input logic          drq,
  input logic          lost,
  input logic [DW-1:0] disk_out
);

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!lost && drq == $past(wr_mode)));

  p_tick_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && byte_tick && !start && !stop) |=> drq);

  p_rd_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wmode && host_rd && !byte_tick && !start && !stop) |=> !drq);

  p_miss_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(drq && byte_tick));

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wmode && byte_tick && drq && !host_wr && !start && !stop) |-> disk_out == '0);

  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !start) |=> lost);

  p_idle_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !drq);

endmodule

bind drq_lost_tracker drq_lost_tracker_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .wr_mode(wr_mode),
  .byte_tick(byte_tick), .host_rd(host_rd), .host_wr(host_wr),
  .active(active), .wmode(wmode), .drq(drq), .lost(lost), .disk_out(disk_out)
);

// File: tb/drq_lost_tracker_test.sv
module drq_lost_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr_mode = 1'b0, stop = 1'b0, byte_tick = 1'b0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] disk_byte = '0, host_din = '0;
  logic drq, lost;
  logic [7:0] dreg, disk_out;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  drq_lost_tracker #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode), .stop(stop),
    .byte_tick(byte_tick), .disk_byte(disk_byte), .host_rd(host_rd),
    .host_wr(host_wr), .host_din(host_din), .drq(drq), .lost(lost),
    .dreg(dreg), .disk_out(disk_out)
  );

  // {tick, rd, byte[7:0], exp_drq, exp_lost, exp_dreg[7:0]}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hA5, 1'b1, 1'b0, 8'hA5},  // R3
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hA5},  // R4
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'hA5},
    {1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C},  // R3
    {1'b1, 1'b1, 8'h71, 1'b1, 1'b0, 8'h71},  // same-cycle service
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h71},  // R4
    {1'b1, 1'b0, 8'h12, 1'b1, 1'b0, 8'h12},
    {1'b1, 1'b0, 8'h9E, 1'b1, 1'b1, 8'h9E},  // R5 overrun
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h9E},  // R8
    {1'b1, 1'b0, 8'h44, 1'b1, 1'b1, 8'h44}   // R8
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    start = 0; stop = 0; byte_tick = 0; host_rd = 0; host_wr = 0;
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    chk("R1 drq", {7'd0, drq}, 8'd0);
    chk("R1 lost", {7'd0, lost}, 8'd0);
    chk("R1 dreg", dreg, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    start = 1; wr_mode = 0; cyc();
    chk("R2 read drq", {7'd0, drq}, 8'd0);
    for (int i = 0; i < NV; i++) begin
      byte_tick = VEC[i][19]; host_rd = VEC[i][18]; disk_byte = VEC[i][17:10];
      cyc();
      chk($sformatf("R3/R4/R5 vec%0d drq", i), {7'd0, drq}, {7'd0, VEC[i][9]});
      chk($sformatf("R5/R8 vec%0d lost", i), {7'd0, lost}, {7'd0, VEC[i][8]});
      chk($sformatf("R3 vec%0d dreg", i), dreg, VEC[i][7:0]);
    end

    // R10: wrong-direction write during read
    host_wr = 1; host_din = 8'h55; cyc();
    chk("R10 dreg", dreg, 8'h44);
    chk("R10 drq", {7'd0, drq}, 8'd1);

    // R2: new write command clears lost, preloads request
    start = 1; wr_mode = 1; cyc();
    chk("R2 lost cleared", {7'd0, lost}, 8'd0);
    chk("R2 write drq", {7'd0, drq}, 8'd1);
    chk("R2 dreg cleared", dreg, 8'h00);

    host_wr = 1; host_din = 8'h5A; cyc();
    chk("R4 write drq", {7'd0, drq}, 8'd0);
    chk("R4 write dreg", dreg, 8'h5A);

    byte_tick = 1; #1;
    chk("R6 disk_out", disk_out, 8'h5A);
    cyc();
    chk("R6 drq", {7'd0, drq}, 8'd1);

    byte_tick = 1; host_wr = 1; host_din = 8'hC3; #1;
    chk("R6 same-cycle disk_out", disk_out, 8'hC3);
    cyc();
    chk("R6 same-cycle lost", {7'd0, lost}, 8'd0);

    byte_tick = 1; #1;
    chk("R7 disk_out zero", disk_out, 8'h00);
    cyc();
    chk("R7 lost", {7'd0, lost}, 8'd1);
    chk("R7 drq", {7'd0, drq}, 8'd1);

    host_wr = 1; host_din = 8'h77; cyc();
    chk("R8 lost held", {7'd0, lost}, 8'd1);
    chk("R8 dreg", dreg, 8'h77);

    stop = 1; cyc();
    chk("R9 drq", {7'd0, drq}, 8'd0);
    chk("R9 lost kept", {7'd0, lost}, 8'd1);

    byte_tick = 1; host_wr = 1; host_din = 8'h88; cyc();
    chk("R9 idle drq", {7'd0, drq}, 8'd0);
    chk("R9 idle dreg", dreg, 8'h77);

    start = 1; wr_mode = 0; cyc();
    chk("R2 restart lost", {7'd0, lost}, 8'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule